// File: doc/BRIEF.md
# Two-Level Discharge Overcurrent Trip Controller

This block is the digital decision stage of a battery discharge protection circuit. Two comparators watch the voltage across the sense element and each hands the block one flag. The moderate flag is high while the sense voltage sits at or above the detection level. The severe flag is high while the sense voltage exceeds a higher, diode-drop level. A third flag tells the block whether a load is still connected. The block's output is an active-low gate drive. Driving it low turns the discharge switch off.

A moderate overcurrent must persist without a break for a programmable number of clock cycles before the block trips. A severe overcurrent trips the block after only the input synchronizer and one state register, whether or not a delay count is running. Once tripped, the block holds the switch off until the load flag shows that the load is gone. A small status output reports whether the block is idle, counting a pending moderate event, or tripped.

All three flags are asynchronous to the block clock, and each one passes through its own two-stage synchronizer. These are plain control pins, so no handshake is involved.

Top module: `ocp_trip_ctrl`

## Requirements
- R1: After reset, `gate_n_o` is 1 (switch enabled) and `mode_o` is 2'b00 (idle).
- R2: With `ovr_mod_i` held high and `ovr_sev_i` low, the block trips on the (D+3)-th rising edge after the flag rises, where D = `trip_dly_i`. After D+2 edges it is not yet tripped, and for D ≥ 1 it reports `mode_o` = 2'b01 (pending) from the third edge on.
- R3: If `ovr_mod_i` falls before the trip, the pending count is discarded and `mode_o` returns to 2'b00. A later rise counts again from zero, so it once more needs D+3 edges.
- R4: `ovr_sev_i` high trips the block on the third rising edge. This holds from idle and also while a long moderate count is pending, and `trip_dly_i` has no effect on it.
- R5: While tripped, `gate_n_o` is 0 and `mode_o` is 2'b10.
- R6: A trip is latched. Dropping `ovr_mod_i` and `ovr_sev_i` leaves the block tripped for as long as `load_on_i` stays high.
- R7: When `load_on_i` goes low during a trip, the block leaves the tripped state on the third rising edge: `gate_n_o` returns to 1 and `mode_o` to 2'b00. After two edges it is still tripped.
- R8: With `trip_dly_i` = 0, a moderate overcurrent trips on the third edge and never reports pending.
- R9: `mode_o` never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_mod_i | input | 1 | Sense voltage at or above the moderate detection level (asynchronous) |
| ovr_sev_i | input | 1 | Sense voltage above the severe (short-circuit) level (asynchronous) |
| load_on_i | input | 1 | Load still connected (asynchronous) |
| trip_dly_i | input | 16 | Moderate-overcurrent delay D in clock cycles |
| gate_n_o | output | 1 | Active-low discharge gate drive; 0 switches the discharge path off |
| mode_o | output | 2 | 00 idle, 01 pending, 10 tripped |

## Verification
A table of moderate-overcurrent pulses tests the delay path. Each pulse is either exactly D+3 edges long or one edge shorter, and the table covers delays of 0, 1, small and medium size. These pairs catch any off-by-one in the count and any error in the zero-delay shortcut. A directed test breaks the moderate flag for a single cycle in the middle of a count. It shows whether the count truly restarts or only pauses.

Further directed tests apply the severe flag from idle and again deep inside a long pending count. They show whether the short path really bypasses the delay. A final test removes all fault flags while the load stays connected, then drops the load. This separates a latched trip from one that follows the flags.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_PEND = 2'b01,
    MODE_TRIP = 2'b10
  } ocp_mode_e;
endpackage

// File: rtl/ocp_sync.sv
// Multi-bit flag synchronizer: each bit passes through STAGES flops.
module ocp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ocp_delay_cnt.sv
// Persistence counter for the moderate-overcurrent path.
module ocp_delay_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ocp_trip_fsm.sv
// Idle / pending / tripped decision state machine.
module ocp_trip_fsm
  import ocp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_s_i,
  input  logic          sev_s_i,
  input  logic          load_s_i,
  input  logic [CW-1:0] dly_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_inc_o,
  output ocp_mode_e     state_o
);
  ocp_mode_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      MODE_IDLE: begin
        if (sev_s_i)                      nxt = MODE_TRIP;
        else if (mod_s_i)                 nxt = (dly_i == '0) ? MODE_TRIP : MODE_PEND;
      end
      MODE_PEND: begin
        if (sev_s_i)                      nxt = MODE_TRIP;
        else if (!mod_s_i)                nxt = MODE_IDLE;
        else if (cnt_i >= dly_i)          nxt = MODE_TRIP;
      end
      MODE_TRIP: begin
        if (!load_s_i)                    nxt = MODE_IDLE;
      end
      default:                            nxt = MODE_IDLE;
    endcase
  end

  assign cnt_inc_o = (nxt == MODE_PEND);
  assign cnt_clr_o = (nxt != MODE_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= MODE_IDLE;
    else        state_o <= nxt;
  end

  // R3: losing the moderate flag while pending abandons the count
  a_r3_pend_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == MODE_PEND && !mod_s_i && !sev_s_i) |=> state_o == MODE_IDLE);
  // R3: counter sits at zero whenever idle, so the next count starts fresh
  a_r3_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == MODE_IDLE) |-> cnt_i == '0);
  // R4: severe flag trips on the next edge from any non-tripped state
  a_r4_sev_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (sev_s_i && state_o != MODE_TRIP) |=> state_o == MODE_TRIP);
  // R6: trip latched while load remains
  a_r6_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == MODE_TRIP && load_s_i) |=> state_o == MODE_TRIP);
  // R7: load removal releases the trip
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == MODE_TRIP && !load_s_i) |=> state_o == MODE_IDLE);
  // R9: unused encoding never appears
  a_r9_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);
endmodule

// File: rtl/ocp_trip_ctrl.sv
// Two-level discharge overcurrent trip controller (top).
module ocp_trip_ctrl
  import ocp_pkg::*;
#(
  parameter int DLY_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_mod_i,
  input  logic             ovr_sev_i,
  input  logic             load_on_i,
  input  logic [DLY_W-1:0] trip_dly_i,
  output logic             gate_n_o,
  output logic [1:0]       mode_o
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0] flags_s;
  logic [DLY_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;
  ocp_mode_e        state;

  ocp_sync #(.W(NFLAG), .STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({load_on_i, ovr_sev_i, ovr_mod_i}),
    .q_o   (flags_s)
  );

  ocp_delay_cnt #(.CW(DLY_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  ocp_trip_fsm #(.CW(DLY_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_s_i   (flags_s[0]),
    .sev_s_i   (flags_s[1]),
    .load_s_i  (flags_s[2]),
    .dly_i     (trip_dly_i),
    .cnt_i     (cnt),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .state_o   (state)
  );

  assign gate_n_o = (state != MODE_TRIP);
  assign mode_o   = state;

  // R2: a pending count never overtakes the programmed delay
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(trip_dly_i) && state == MODE_PEND) |-> cnt <= trip_dly_i);
endmodule

// File: tb/ocp_trip_ctrl_tb.sv
module ocp_trip_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovr_mod = 1'b0, ovr_sev = 1'b0, load_on = 1'b1;
  logic [15:0] dly = '0;
  logic        gate_n;
  logic [1:0]  mode;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ocp_trip_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ovr_mod_i(ovr_mod), .ovr_sev_i(ovr_sev),
    .load_on_i(load_on), .trip_dly_i(dly), .gate_n_o(gate_n), .mode_o(mode)
  );

  // {delay D, edges held H}; trip expected when H >= D+3
  localparam logic [31:0] VEC [0:7] = '{
    {16'd5, 16'd8}, {16'd5, 16'd7}, {16'd0, 16'd3}, {16'd0, 16'd2},
    {16'd20, 16'd23}, {16'd20, 16'd22}, {16'd1, 16'd4}, {16'd1, 16'd3}
  };

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] exp_mode);
    logic exp_gate;
    exp_gate = (exp_mode != 2'b10);
    total++;
    if (mode !== exp_mode || gate_n !== exp_gate) begin
      bad++;
      $display("FAIL %s: mode=%b gate_n=%b expected mode=%b gate_n=%b",
               req, mode, gate_n, exp_mode, exp_gate);
    end
  endtask

  task automatic release_all();
    ovr_mod = 0; ovr_sev = 0; load_on = 0;
    edges(5);
    load_on = 1;
    edges(3);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk("R1 reset held", 2'b00);
    rst_n = 1;
    edges(2);
    chk("R1 after reset", 2'b00);

    // table walk: R2 / R8 delay path
    for (int v = 0; v < 8; v++) begin
      int d, h;
      logic [1:0] em;
      d = int'(VEC[v][31:16]);
      h = int'(VEC[v][15:0]);
      em = (h >= d + 3) ? 2'b10 : ((h >= 3) ? 2'b01 : 2'b00);
      dly = 16'(d);
      ovr_mod = 1;
      edges(h);
      chk((d == 0) ? "R8 zero delay" : "R2 delay path", em);
      release_all();
      chk("R7 idle after release", 2'b00);
    end

    // R3: one-cycle break restarts count
    dly = 16'd10;
    ovr_mod = 1;
    edges(8);
    chk("R3 pending before break", 2'b01);
    ovr_mod = 0;
    edges(1);
    ovr_mod = 1;
    edges(12);
    chk("R3 restarted count not done", 2'b01);
    edges(1);
    chk("R3 restarted count trips", 2'b10);
    release_all();

    // R4: severe overrides long pending count
    dly = 16'd1000;
    ovr_mod = 1;
    edges(50);
    chk("R4 long pending", 2'b01);
    ovr_sev = 1;
    edges(2);
    chk("R4 sev not yet", 2'b01);
    edges(1);
    chk("R4 sev trips during pending", 2'b10);

    // R5 / R6: latched with flags removed
    ovr_sev = 0; ovr_mod = 0;
    edges(10);
    chk("R6 latched after flags drop", 2'b10);
    chk("R5 gate low while tripped", 2'b10);

    // R7: load release timing
    load_on = 0;
    edges(2);
    chk("R7 still tripped after 2 edges", 2'b10);
    edges(1);
    chk("R7 released on third edge", 2'b00);
    load_on = 1;
    edges(3);

    // R4: severe from idle with large delay
    dly = 16'd60000;
    ovr_sev = 1;
    edges(2);
    chk("R4 idle sev not yet", 2'b00);
    edges(1);
    chk("R4 idle sev trips", 2'b10);
    chk("R9 mode legal", 2'b10);
    release_all();
    chk("R9 idle after final release", 2'b00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule